// File: doc/BRIEF.md
# Ingress QoS Classifier and Marker

This block is the per-port ingress QoS stage of an Ethernet switch. It accepts already-parsed frame descriptors on a valid/ready stream. Each descriptor carries the VLAN priority code point, the IP DSCP and the MAC and IP source and destination addresses. For every frame the block picks a three-bit service class and writes that class back into the priority fields of the descriptor, so later stages see the decision. It then sends the frame to one of several ingress priority queues through a queue index.

A two-bit trust setting controls each port. Bit 0 set honours the VLAN priority. Bit 1 set honours the upper three DSCP bits. If both bits are set the VLAN priority wins. If both bits are clear the port is untrusted: classification is skipped, the frame is flagged, and it goes to queue 0 in arrival order with its priority fields unchanged. On a trusted port, a small table of masked address rules can override the claimed priority. The lowest-numbered rule that matches wins. Each frame passes through two register stages, so the latency is fixed.

Top module: `qos_ingress_marker`

## Requirements
- R1: With trust 2'b01 (VLAN priority honoured), a frame with a VLAN tag and no rule match gets class = its 3-bit PCP. Without a tag it gets `cfg_default_cls`.
- R2: With trust 2'b10 (DSCP honoured), an IP frame with no rule match gets class = DSCP[5:3]. A non-IP frame gets `cfg_default_cls`.
- R3: With trust 2'b11, the PCP takes precedence when a VLAN tag is present. Otherwise DSCP[5:3] is used when the frame is IP. Otherwise `cfg_default_cls` is used.
- R4: On a trusted port, rule i matches when it is enabled and `(key ^ value) & mask == 0`. The key is chosen by the 2-bit field select: 0 = MAC destination, 1 = MAC source, 2 = IP destination, 3 = IP source. IP keys are zero-extended to 48 bits and can match only when `in_has_ip` is 1. The lowest-indexed matching rule sets the class, ahead of any PCP or DSCP.
- R5: For a trusted frame the marked outputs are `out_pcp = class` and `out_dscp = {class, in_dscp[2:0]}`.
- R6: With trust 2'b00, the output has `out_untrusted = 1`, `out_cls = 0` and `out_queue = 0`. PCP and DSCP pass through unchanged, rules have no effect, and frames leave in arrival order. Trusted frames carry `out_untrusted = 0`.
- R7: For a trusted frame, `out_queue = class >> (3 - log2(NUM_QUEUES))`, which is class[2:1] for 4 queues.
- R8: A frame accepted at clock edge E appears on `out_valid` after edge E+2 when the output was not stalled at edge E+1.
- R9: While `out_valid` is high and `out_ready` is low, every output field holds its value. No frame is lost, duplicated or reordered under backpressure.
- R10: While reset is asserted, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trust | input | 2 | Trust setting: bit0 honours PCP, bit1 honours DSCP, 0 = untrusted |
| cfg_default_cls | input | 3 | Class used when no priority source applies |
| cfg_rule_en | input | NUM_RULES | Per-rule enable |
| cfg_rule_fld | input | 2*NUM_RULES | Per-rule key select |
| cfg_rule_val | input | 48*NUM_RULES | Per-rule match value |
| cfg_rule_mask | input | 48*NUM_RULES | Per-rule compare mask |
| cfg_rule_cls | input | 3*NUM_RULES | Per-rule assigned class |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Input descriptor accepted |
| in_id | input | ID_W | Frame handle carried through |
| in_has_vlan | input | 1 | Frame carries a VLAN tag |
| in_pcp | input | 3 | VLAN priority code point |
| in_has_ip | input | 1 | Frame carries an IP header |
| in_dscp | input | 6 | IP DSCP |
| in_mac_da | input | 48 | MAC destination |
| in_mac_sa | input | 48 | MAC source |
| in_ip_da | input | 32 | IP destination |
| in_ip_sa | input | 32 | IP source |
| out_valid | output | 1 | Output descriptor valid |
| out_ready | input | 1 | Downstream accepts |
| out_id | output | ID_W | Frame handle |
| out_cls | output | 3 | Assigned class |
| out_untrusted | output | 1 | Frame came from an untrusted port |
| out_queue | output | log2(NUM_QUEUES) | Ingress queue index |
| out_pcp | output | 3 | Marked PCP |
| out_dscp | output | 6 | Marked DSCP |

## Verification
The assertions assume that the upstream side holds a descriptor stable while `in_valid` waits for `in_ready`. They also assume that the trust and rule settings do not change while frames are inside the pipeline, because the rules are applied one stage after the trust setting is captured. The stimulus meets both assumptions in the same way: each descriptor stays on the pins until it is accepted, and settings change only after every expected frame has drained. Backpressure comes from a pseudo-random `out_ready` in one phase, and the exact-latency check runs only while `out_ready` is held high.

// File: rtl/qos_pkg.sv
package qos_pkg;

    parameter int KEY_W  = 48;
    parameter int IP_W   = 32;
    parameter int CLS_W  = 3;
    parameter int DSCP_W = 6;
    parameter int FLD_W  = 2;

    // bit0: honour VLAN priority, bit1: honour DSCP
    typedef enum logic [1:0] {
        TRUST_NONE = 2'd0,
        TRUST_PCP  = 2'd1,
        TRUST_DSCP = 2'd2,
        TRUST_BOTH = 2'd3
    } trust_e;

    typedef enum logic [FLD_W-1:0] {
        FLD_MAC_DST = 2'd0,
        FLD_MAC_SRC = 2'd1,
        FLD_IP_DST  = 2'd2,
        FLD_IP_SRC  = 2'd3
    } field_e;

    typedef struct packed {
        logic              has_vlan;
        logic [CLS_W-1:0]  pcp;
        logic              has_ip;
        logic [DSCP_W-1:0] dscp;
        logic [KEY_W-1:0]  mac_da;
        logic [KEY_W-1:0]  mac_sa;
        logic [IP_W-1:0]   ip_da;
        logic [IP_W-1:0]   ip_sa;
    } hdr_t;

endpackage

// File: rtl/qos_rule_match.sv
module qos_rule_match
    import qos_pkg::*;
#(
    parameter int NUM_RULES = 4
) (
    input  hdr_t                       hdr_i,
    input  logic [NUM_RULES-1:0]       rule_en_i,
    input  logic [NUM_RULES*FLD_W-1:0] rule_fld_i,
    input  logic [NUM_RULES*KEY_W-1:0] rule_val_i,
    input  logic [NUM_RULES*KEY_W-1:0] rule_mask_i,
    input  logic [NUM_RULES*CLS_W-1:0] rule_cls_i,
    output logic                       hit_o,
    output logic [CLS_W-1:0]           cls_o
);

    logic [NUM_RULES-1:0] hits;

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        field_e           fld;
        logic [KEY_W-1:0] key;
        logic             key_ok;

        assign fld = field_e'(rule_fld_i[g*FLD_W +: FLD_W]);

        always_comb begin
            key_ok = 1'b1;
            case (fld)
                FLD_MAC_DST: key = hdr_i.mac_da;
                FLD_MAC_SRC: key = hdr_i.mac_sa;
                FLD_IP_DST: begin
                    key    = KEY_W'(hdr_i.ip_da);
                    key_ok = hdr_i.has_ip;
                end
                default: begin
                    key    = KEY_W'(hdr_i.ip_sa);
                    key_ok = hdr_i.has_ip;
                end
            endcase
        end

        assign hits[g] = rule_en_i[g] && key_ok &&
                         (((key ^ rule_val_i[g*KEY_W +: KEY_W]) &
                           rule_mask_i[g*KEY_W +: KEY_W]) == '0);
    end

    // lowest index wins: scan downward so the last write is the lowest hit
    always_comb begin
        hit_o = |hits;
        cls_o = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                cls_o = rule_cls_i[i*CLS_W +: CLS_W];
            end
        end
    end

endmodule

// File: rtl/qos_class_pick.sv
module qos_class_pick
    import qos_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    localparam int QW        = $clog2(NUM_QUEUES),
    localparam int SHIFT     = CLS_W - QW
) (
    input  trust_e            trust_i,
    input  hdr_t              hdr_i,
    input  logic              rule_hit_i,
    input  logic [CLS_W-1:0]  rule_cls_i,
    input  logic [CLS_W-1:0]  dflt_cls_i,
    output logic [CLS_W-1:0]  cls_o,
    output logic              untr_o,
    output logic [QW-1:0]     queue_o,
    output logic [CLS_W-1:0]  pcp_o,
    output logic [DSCP_W-1:0] dscp_o
);

    logic use_pcp;
    logic use_dscp;

    always_comb begin
        untr_o   = (trust_i == TRUST_NONE);
        use_pcp  = trust_i[0] && hdr_i.has_vlan;
        use_dscp = trust_i[1] && hdr_i.has_ip;

        if (untr_o) begin
            cls_o = '0;
        end else if (rule_hit_i) begin
            cls_o = rule_cls_i;
        end else if (use_pcp) begin
            cls_o = hdr_i.pcp;
        end else if (use_dscp) begin
            cls_o = hdr_i.dscp[DSCP_W-1 -: CLS_W];
        end else begin
            cls_o = dflt_cls_i;
        end

        if (untr_o) begin
            queue_o = '0;
            pcp_o   = hdr_i.pcp;
            dscp_o  = hdr_i.dscp;
        end else begin
            queue_o = QW'(cls_o >> SHIFT);
            pcp_o   = cls_o;
            dscp_o  = {cls_o, hdr_i.dscp[DSCP_W-CLS_W-1:0]};
        end
    end

endmodule

// File: rtl/qos_ingress_marker.sv
module qos_ingress_marker
    import qos_pkg::*;
#(
    parameter int NUM_RULES  = 4,
    parameter int NUM_QUEUES = 4,
    parameter int ID_W       = 8,
    localparam int QW        = $clog2(NUM_QUEUES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 cfg_trust,
    input  logic [CLS_W-1:0]           cfg_default_cls,
    input  logic [NUM_RULES-1:0]       cfg_rule_en,
    input  logic [NUM_RULES*FLD_W-1:0] cfg_rule_fld,
    input  logic [NUM_RULES*KEY_W-1:0] cfg_rule_val,
    input  logic [NUM_RULES*KEY_W-1:0] cfg_rule_mask,
    input  logic [NUM_RULES*CLS_W-1:0] cfg_rule_cls,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [ID_W-1:0]            in_id,
    input  logic                       in_has_vlan,
    input  logic [CLS_W-1:0]           in_pcp,
    input  logic                       in_has_ip,
    input  logic [DSCP_W-1:0]          in_dscp,
    input  logic [KEY_W-1:0]           in_mac_da,
    input  logic [KEY_W-1:0]           in_mac_sa,
    input  logic [IP_W-1:0]            in_ip_da,
    input  logic [IP_W-1:0]            in_ip_sa,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [ID_W-1:0]            out_id,
    output logic [CLS_W-1:0]           out_cls,
    output logic                       out_untrusted,
    output logic [QW-1:0]              out_queue,
    output logic [CLS_W-1:0]           out_pcp,
    output logic [DSCP_W-1:0]          out_dscp
);

    typedef struct packed {
        logic              s1_v;
        trust_e            s1_trust;
        hdr_t              s1_hdr;
        logic [ID_W-1:0]   s1_id;
        logic              s2_v;
        logic [ID_W-1:0]   s2_id;
        logic [CLS_W-1:0]  s2_cls;
        logic              s2_untr;
        logic [QW-1:0]     s2_q;
        logic [CLS_W-1:0]  s2_pcp;
        logic [DSCP_W-1:0] s2_dscp;
    } pipe_t;

    pipe_t st_q, st_d;

    logic              rule_hit;
    logic [CLS_W-1:0]  rule_cls;
    logic [CLS_W-1:0]  pick_cls;
    logic              pick_untr;
    logic [QW-1:0]     pick_q;
    logic [CLS_W-1:0]  pick_pcp;
    logic [DSCP_W-1:0] pick_dscp;
    logic              s1_adv;
    logic              s2_adv;

    qos_rule_match #(
        .NUM_RULES (NUM_RULES)
    ) u_match (
        .hdr_i       (st_q.s1_hdr),
        .rule_en_i   (cfg_rule_en),
        .rule_fld_i  (cfg_rule_fld),
        .rule_val_i  (cfg_rule_val),
        .rule_mask_i (cfg_rule_mask),
        .rule_cls_i  (cfg_rule_cls),
        .hit_o       (rule_hit),
        .cls_o       (rule_cls)
    );

    qos_class_pick #(
        .NUM_QUEUES (NUM_QUEUES)
    ) u_pick (
        .trust_i    (st_q.s1_trust),
        .hdr_i      (st_q.s1_hdr),
        .rule_hit_i (rule_hit),
        .rule_cls_i (rule_cls),
        .dflt_cls_i (cfg_default_cls),
        .cls_o      (pick_cls),
        .untr_o     (pick_untr),
        .queue_o    (pick_q),
        .pcp_o      (pick_pcp),
        .dscp_o     (pick_dscp)
    );

    always_comb begin
        st_d   = st_q;
        s2_adv = !st_q.s2_v || out_ready;
        s1_adv = !st_q.s1_v || s2_adv;

        if (s2_adv) begin
            st_d.s2_v    = st_q.s1_v;
            st_d.s2_id   = st_q.s1_id;
            st_d.s2_cls  = pick_cls;
            st_d.s2_untr = pick_untr;
            st_d.s2_q    = pick_q;
            st_d.s2_pcp  = pick_pcp;
            st_d.s2_dscp = pick_dscp;
        end

        if (s1_adv) begin
            st_d.s1_v            = in_valid;
            st_d.s1_trust        = trust_e'(cfg_trust);
            st_d.s1_id           = in_id;
            st_d.s1_hdr.has_vlan = in_has_vlan;
            st_d.s1_hdr.pcp      = in_pcp;
            st_d.s1_hdr.has_ip   = in_has_ip;
            st_d.s1_hdr.dscp     = in_dscp;
            st_d.s1_hdr.mac_da   = in_mac_da;
            st_d.s1_hdr.mac_sa   = in_mac_sa;
            st_d.s1_hdr.ip_da    = in_ip_da;
            st_d.s1_hdr.ip_sa    = in_ip_sa;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready      = s1_adv;
    assign out_valid     = st_q.s2_v;
    assign out_id        = st_q.s2_id;
    assign out_cls       = st_q.s2_cls;
    assign out_untrusted = st_q.s2_untr;
    assign out_queue     = st_q.s2_q;
    assign out_pcp       = st_q.s2_pcp;
    assign out_dscp      = st_q.s2_dscp;

endmodule

// File: rtl/qos_ingress_marker_chk.sv
module qos_ingress_marker_chk #(
    parameter int NUM_QUEUES = 4,
    parameter int ID_W       = 8,
    localparam int QW        = $clog2(NUM_QUEUES),
    localparam int SHIFT     = 3 - QW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [ID_W-1:0] out_id,
    input logic [2:0]      out_cls,
    input logic            out_untrusted,
    input logic [QW-1:0]   out_queue,
    input logic [2:0]      out_pcp,
    input logic [5:0]      out_dscp
);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_cls)
            && $stable(out_untrusted) && $stable(out_queue) && $stable(out_pcp)
            && $stable(out_dscp));

    p_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_untrusted |-> out_pcp == out_cls && out_dscp[5:3] == out_cls);

    p_queue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_untrusted |-> out_queue == QW'(out_cls >> SHIFT));

    p_untr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_untrusted |-> out_queue == '0 && out_cls == '0);

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_ready, 2) && $past(!out_valid || out_ready, 1) |-> out_valid);

endmodule

bind qos_ingress_marker qos_ingress_marker_chk #(
    .NUM_QUEUES (NUM_QUEUES),
    .ID_W       (ID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_id        (out_id),
    .out_cls       (out_cls),
    .out_untrusted (out_untrusted),
    .out_queue     (out_queue),
    .out_pcp       (out_pcp),
    .out_dscp      (out_dscp)
);

// File: tb/qos_ingress_marker_tb.sv
module qos_ingress_marker_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NR  = 4;
    localparam int  NQ  = 4;
    localparam int  IDW = 8;
    localparam int  QW  = $clog2(NQ);

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [1:0]      cfg_trust;
    logic [2:0]      cfg_default_cls;
    logic            r_en   [NR];
    logic [1:0]      r_fld  [NR];
    logic [47:0]     r_val  [NR];
    logic [47:0]     r_mask [NR];
    logic [2:0]      r_cls  [NR];
    logic [NR-1:0]   cfg_rule_en;
    logic [NR*2-1:0] cfg_rule_fld;
    logic [NR*48-1:0] cfg_rule_val;
    logic [NR*48-1:0] cfg_rule_mask;
    logic [NR*3-1:0] cfg_rule_cls;

    logic            in_valid, in_ready, in_has_vlan, in_has_ip;
    logic [IDW-1:0]  in_id;
    logic [2:0]      in_pcp;
    logic [5:0]      in_dscp;
    logic [47:0]     in_mac_da, in_mac_sa;
    logic [31:0]     in_ip_da, in_ip_sa;
    logic            out_valid, out_ready, out_untrusted;
    logic [IDW-1:0]  out_id;
    logic [2:0]      out_cls, out_pcp;
    logic [QW-1:0]   out_queue;
    logic [5:0]      out_dscp;

    always_comb begin
        for (int i = 0; i < NR; i++) begin
            cfg_rule_en[i]            = r_en[i];
            cfg_rule_fld[i*2 +: 2]    = r_fld[i];
            cfg_rule_val[i*48 +: 48]  = r_val[i];
            cfg_rule_mask[i*48 +: 48] = r_mask[i];
            cfg_rule_cls[i*3 +: 3]    = r_cls[i];
        end
    end

    qos_ingress_marker #(.NUM_RULES(NR), .NUM_QUEUES(NQ), .ID_W(IDW)) u_dut (
        .clk, .rst_n, .cfg_trust, .cfg_default_cls, .cfg_rule_en, .cfg_rule_fld,
        .cfg_rule_val, .cfg_rule_mask, .cfg_rule_cls, .in_valid, .in_ready, .in_id,
        .in_has_vlan, .in_pcp, .in_has_ip, .in_dscp, .in_mac_da, .in_mac_sa,
        .in_ip_da, .in_ip_sa, .out_valid, .out_ready, .out_id, .out_cls,
        .out_untrusted, .out_queue, .out_pcp, .out_dscp
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [IDW-1:0] id;
        logic [2:0]     cls;
        logic           untr;
        logic [QW-1:0]  q;
        logic [2:0]     pcp;
        logic [5:0]     dscp;
        int             acc;
        bit             free;
        string          req;
    } exp_t;

    exp_t  expq[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    free_mode = 1'b1;
    string cur_req = "R1";
    bit    done = 1'b0;
    bit    hold_pend = 1'b0;
    logic [IDW-1:0] hold_id;
    logic [2:0]     hold_cls;

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic exp_t predict();
        exp_t        e;
        logic [47:0] key;
        bit          ok, hit;
        logic [2:0]  cls;
        e.id  = in_id;
        e.acc = cyc;
        e.free = free_mode;
        e.req = cur_req;
        if (cfg_trust == 2'b00) begin
            e.untr = 1'b1; e.cls = 3'd0; e.q = '0; e.pcp = in_pcp; e.dscp = in_dscp;
            return e;
        end
        hit = 1'b0;
        cls = cfg_default_cls;
        for (int i = 0; i < NR; i++) begin
            if (!hit) begin
                case (r_fld[i])
                    2'd0:    key = in_mac_da;
                    2'd1:    key = in_mac_sa;
                    2'd2:    key = {16'h0, in_ip_da};
                    default: key = {16'h0, in_ip_sa};
                endcase
                ok = (r_fld[i] < 2) || in_has_ip;
                if (r_en[i] && ok && ((key & r_mask[i]) == (r_val[i] & r_mask[i]))) begin
                    hit = 1'b1;
                    cls = r_cls[i];
                end
            end
        end
        if (!hit) begin
            if (cfg_trust[0] && in_has_vlan)     cls = in_pcp;
            else if (cfg_trust[1] && in_has_ip)  cls = in_dscp[5:3];
        end
        e.untr = 1'b0;
        e.cls  = cls;
        e.q    = QW'(int'(cls) / (8 / NQ));
        e.pcp  = cls;
        e.dscp = {cls, in_dscp[2:0]};
        return e;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // reference model: compare on every falling edge
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            if (hold_pend) begin
                chk("R9", "held valid", {63'd0, out_valid}, 64'd1);
                chk("R9", "held id", {56'd0, out_id}, {56'd0, hold_id});
                chk("R9", "held class", {61'd0, out_cls}, {61'd0, hold_cls});
            end
            hold_pend = out_valid && !out_ready;
            hold_id   = out_id;
            hold_cls  = out_cls;
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk("R6", "unexpected output frame", 64'd1, 64'd0);
                end else begin
                    e = expq.pop_front();
                    chk("R6", "order id", {56'd0, out_id}, {56'd0, e.id});
                    chk(e.req, "class", {61'd0, out_cls}, {61'd0, e.cls});
                    chk("R6", "untrusted flag", {63'd0, out_untrusted}, {63'd0, e.untr});
                    chk("R7", "queue", {62'd0, out_queue}, {62'd0, e.q});
                    chk("R5", "marked pcp", {61'd0, out_pcp}, {61'd0, e.pcp});
                    chk("R5", "marked dscp", {58'd0, out_dscp}, {58'd0, e.dscp});
                    if (e.free && free_mode) begin
                        chk("R8", "latency", 64'(cyc - e.acc), 64'd2);
                    end
                end
            end
            if (in_valid && in_ready) begin
                expq.push_back(predict());
            end
        end
    end

    task automatic send(input logic [IDW-1:0] id, input logic vl, input logic [2:0] pcp,
                        input logic ip, input logic [5:0] dscp, input logic [47:0] mda,
                        input logic [47:0] msa, input logic [31:0] ida, input logic [31:0] isa);
        in_id = id; in_has_vlan = vl; in_pcp = pcp; in_has_ip = ip; in_dscp = dscp;
        in_mac_da = mda; in_mac_sa = msa; in_ip_da = ida; in_ip_sa = isa;
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic send_rand(input logic [IDW-1:0] id);
        logic [31:0] isa;
        logic [47:0] mda;
        isa = ($urandom_range(0, 2) == 0) ? 32'h0A01_0200 + 32'($urandom_range(0, 255))
                                          : $urandom;
        mda = ($urandom_range(0, 3) == 0) ? 48'h0200_0000_00AA : {16'h0200, $urandom};
        send(id, 1'($urandom), 3'($urandom), 1'($urandom), 6'($urandom),
             mda, {16'h0400, $urandom}, $urandom, isa);
    endtask

    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            out_ready = free_mode ? 1'b1 : ($urandom_range(0, 2) != 0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b0; in_id = '0; in_has_vlan = 1'b0; in_pcp = '0; in_has_ip = 1'b0;
        in_dscp = '0; in_mac_da = '0; in_mac_sa = '0; in_ip_da = '0; in_ip_sa = '0;
        cfg_trust = 2'b01; cfg_default_cls = 3'd3;
        for (int i = 0; i < NR; i++) begin
            r_en[i] = 1'b0; r_fld[i] = '0; r_val[i] = '0; r_mask[i] = '0; r_cls[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "valid in reset", {63'd0, out_valid}, 64'd0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "valid after reset", {63'd0, out_valid}, 64'd0);
        chk("R10", "ready after reset", {63'd0, in_ready}, 64'd1);

        // R1: PCP honoured
        cur_req = "R1";
        for (int p = 0; p < 8; p++) begin
            send(8'(p), 1'b1, 3'(p), 1'b1, 6'h3F - 6'(p), 48'h1, 48'h2, 32'h1, 32'h2);
        end
        send(8'h10, 1'b0, 3'd7, 1'b1, 6'h38, 48'h1, 48'h2, 32'h1, 32'h2);
        drain();

        // R2: DSCP honoured
        cur_req = "R2"; cfg_trust = 2'b10; cfg_default_cls = 3'd5;
        for (int d = 0; d < 64; d += 9) begin
            send(8'(8'h20 + d), 1'b1, 3'd1, 1'b1, 6'(d), 48'h1, 48'h2, 32'h1, 32'h2);
        end
        send(8'h60, 1'b1, 3'd6, 1'b0, 6'h3F, 48'h1, 48'h2, 32'h1, 32'h2);
        drain();

        // R3: both honoured, PCP precedence
        cur_req = "R3"; cfg_trust = 2'b11; cfg_default_cls = 3'd2;
        send(8'h70, 1'b1, 3'd1, 1'b1, 6'h38, 48'h1, 48'h2, 32'h1, 32'h2);
        send(8'h71, 1'b0, 3'd1, 1'b1, 6'h28, 48'h1, 48'h2, 32'h1, 32'h2);
        send(8'h72, 1'b0, 3'd7, 1'b0, 6'h38, 48'h1, 48'h2, 32'h1, 32'h2);
        send(8'h73, 1'b1, 3'd0, 1'b0, 6'h38, 48'h1, 48'h2, 32'h1, 32'h2);
        drain();

        // R4: override rules, first match wins
        cur_req = "R4";
        r_en[0] = 1'b1; r_fld[0] = 2'd3; r_val[0] = 48'h0A01_0200; r_mask[0] = 48'hFFFF_FF00; r_cls[0] = 3'd6;
        r_en[1] = 1'b1; r_fld[1] = 2'd0; r_val[1] = 48'h0200_0000_00AA; r_mask[1] = '1; r_cls[1] = 3'd1;
        r_en[2] = 1'b1; r_fld[2] = 2'd3; r_val[2] = 48'h0A01_0000; r_mask[2] = 48'hFFFF_0000; r_cls[2] = 3'd2;
        r_en[3] = 1'b0; r_fld[3] = 2'd1; r_val[3] = '0; r_mask[3] = '0; r_cls[3] = 3'd7;
        send(8'h80, 1'b1, 3'd0, 1'b1, 6'h00, 48'h1, 48'h2, 32'h1, 32'h0A01_0205);
        send(8'h81, 1'b1, 3'd0, 1'b1, 6'h00, 48'h1, 48'h2, 32'h1, 32'h0A01_FF01);
        send(8'h82, 1'b1, 3'd5, 1'b1, 6'h00, 48'h0200_0000_00AA, 48'h2, 32'h1, 32'h0B00_0001);
        send(8'h83, 1'b1, 3'd4, 1'b0, 6'h00, 48'h1, 48'h2, 32'h1, 32'h0A01_0205);
        send(8'h84, 1'b1, 3'd4, 1'b1, 6'h00, 48'h0200_0000_00AA, 48'h2, 32'h1, 32'h0A01_0201);
        send(8'h85, 1'b0, 3'd4, 1'b0, 6'h00, 48'h3, 48'h4, 32'h1, 32'h2);
        drain();

        // R6: untrusted port ignores rules and tags
        cur_req = "R6"; cfg_trust = 2'b00;
        send(8'h90, 1'b1, 3'd7, 1'b1, 6'h3B, 48'h0200_0000_00AA, 48'h2, 32'h1, 32'h0A01_0205);
        send(8'h91, 1'b1, 3'd5, 1'b1, 6'h15, 48'h1, 48'h2, 32'h1, 32'h2);
        send(8'h92, 1'b0, 3'd2, 1'b0, 6'h2A, 48'h1, 48'h2, 32'h1, 32'h2);
        drain();

        // R9: random backpressure on a trusted port
        cur_req = "R9"; cfg_trust = 2'b11; free_mode = 1'b0;
        for (int k = 0; k < 60; k++) send_rand(8'(k));
        drain();
        free_mode = 1'b1;
        repeat (2) @(posedge clk);
        #1;

        // R8: back-to-back traffic, no stall
        cur_req = "R8"; cfg_trust = 2'b01;
        for (int k = 0; k < 30; k++) send_rand(8'(8'hA0 + k));
        drain();

        chk("R9", "no frame left behind", 64'(expq.size()), 64'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule